// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Optional Ninth Bit

This block is a full-duplex asynchronous serial receiver and transmitter. Each character on the line is framed by one low start bit and one high stop bit. It carries eight data bits, or nine when a nine-bit format is selected. The ninth bit is set by a control field. It can be a constant zero, a constant one, or an even-parity bit computed over the eight data bits. Both directions use a shared 16x oversampling tick. That tick comes either from a fixed divide of the system clock, giving a bit of 32 or 64 clocks, or from a single-cycle pulse input driven by an external rate generator.

Software-facing access is register-like. A one-cycle write strobe with a data byte starts a transmission, and a busy flag covers the whole frame. The receiver moves each finished character into a holding register together with its ninth bit and a framing-error flag. It raises a valid flag, and a one-cycle read strobe clears that flag. Because the shift path is separate from the holding register, the next character can be shifted in while the previous one is still waiting to be read.

Top module: `uart9`

## Requirements
- R1: The serial output `txd` is high while idle. A frame starts with one low start bit, sends data least significant bit first, and ends with one high stop bit.
- R2: With `mode` = 2'b00, a frame has 8 data bits and no ninth bit. Each bit lasts 16 `baud_tick` pulses.
- R3: With `mode` = 2'b01 or 2'b1x, a ninth bit follows data bit 7. `bit9_sel` 2'b00 sends 0, 2'b01 sends 1, and 2'b1x sends the XOR of the 8 data bits (even parity).
- R4: With `mode` = 2'b01, each bit lasts 32 system clocks when `div_sel` = 0 and 64 when `div_sel` = 1. In this mode `baud_tick` is ignored.
- R5: The transmitter and receiver operate at the same time without disturbing each other.
- R6: `tx_busy` is high from the cycle after an accepted `tx_wr` until the stop bit has been sent. A `tx_wr` while busy is ignored.
- R7: The receiver samples each bit at oversample ticks 7, 8 and 9 of the bit and takes the majority. A start bit that is not low at its midpoint is discarded, and the receiver returns to idle.
- R8: When the stop bit has been sampled, `rx_valid` rises and `rx_data`/`rx_bit9` hold the character (`rx_bit9` = 0 in 8-bit mode). The held values stay unchanged while the next character is being shifted in. A newer finished character replaces them. `rx_rd` clears `rx_valid` one cycle later.
- R9: A stop bit sampled low sets `rx_ferr` = 1 together with the character, and a high stop bit gives 0. After any frame, the line must be seen high before a new start bit is accepted.
- R10: After reset `txd` = 1, `tx_busy` = 0, `rx_valid` = 0, `rx_data` = 0 and `rx_ferr` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Frame format and rate source (00: 8-bit/ext, 01: 9-bit/divide, 1x: 9-bit/ext) |
| div_sel | input | 1 | Fixed-divide bit period: 0 = 32 clocks, 1 = 64 clocks |
| bit9_sel | input | 2 | Ninth bit source: 00 zero, 01 one, 1x even parity |
| baud_tick | input | 1 | External 16x oversample pulse |
| tx_wr | input | 1 | Write strobe that starts a transmission |
| tx_data | input | 8 | Byte to transmit |
| tx_busy | output | 1 | Transmission in progress |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input (asynchronous) |
| rx_rd | input | 1 | Read strobe that clears `rx_valid` |
| rx_valid | output | 1 | Holding register contains an unread character |
| rx_data | output | 8 | Received data byte |
| rx_bit9 | output | 1 | Received ninth bit |
| rx_ferr | output | 1 | Framing error for the held character |

## Verification
The transmitter loads on the write edge, so `tx_busy` is checked one cycle later. Every transmitted bit is sampled half a bit period after its nominal start. Bit boundaries follow the oversample tick, so they can drift by up to one tick spacing, and centre sampling absorbs that drift. A received character is complete about half a bit after the stop bit begins, after two synchronizer flops and the tick phase. The bench therefore reads the holding register only after the full stop bit has been driven. A read strobe clears `rx_valid` at the next edge, and the bench checks it at the falling edge that follows.

// File: rtl/uart9_pkg.sv
package uart9_pkg;

    localparam int DW  = 8;
    localparam int OVS = 16;

    typedef enum logic [1:0] {
        FMT_8_EXT   = 2'b00,
        FMT_9_DIV   = 2'b01,
        FMT_9_EXT   = 2'b10,
        FMT_9_EXT_B = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        N9_ZERO  = 2'b00,
        N9_ONE   = 2'b01,
        N9_PAR   = 2'b10,
        N9_PAR_B = 2'b11
    } ninth_e;

    typedef enum logic [1:0] {
        LN_IDLE,
        LN_START,
        LN_DATA,
        LN_STOP
    } line_e;

    typedef struct packed {
        logic [DW-1:0] data;
        logic          bit9;
        logic          ferr;
    } rx_word_t;

    function automatic logic fmt_nine(fmt_e f);
        return f != FMT_8_EXT;
    endfunction

    function automatic logic fmt_ext(fmt_e f);
        return f != FMT_9_DIV;
    endfunction

    function automatic logic ninth_of(ninth_e s, logic [DW-1:0] d);
        case (s)
            N9_ZERO: return 1'b0;
            N9_ONE:  return 1'b1;
            default: return ^d;
        endcase
    endfunction

    function automatic logic vote3(logic a, logic b, logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/uart9_tick.sv
module uart9_tick #(
    parameter int OVS    = uart9_pkg::OVS,
    parameter int BIT_LO = 32,
    parameter int BIT_HI = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_sel,
    input  logic div_sel,
    input  logic baud_tick,
    output logic tick
);
    localparam int DIV_LO = BIT_LO / OVS;
    localparam int DIV_HI = BIT_HI / OVS;
    localparam int CW     = (DIV_HI > 1) ? $clog2(DIV_HI) : 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;
    logic          hit;

    assign lim = div_sel ? CW'(DIV_HI - 1) : CW'(DIV_LO - 1);
    assign hit = (cnt_q >= lim);

    always_ff @(posedge clk) begin
        if (rst || ext_sel) cnt_q <= '0;
        else if (hit)       cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end

    assign tick = ext_sel ? baud_tick : hit;

    AST_DIV_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        (!ext_sel && tick) |=> (!tick || ext_sel));   // R4

endmodule

// File: rtl/uart9_tx.sv
module uart9_tx
    import uart9_pkg::*;
#(
    parameter int DW  = uart9_pkg::DW,
    parameter int OVS = uart9_pkg::OVS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          nine,
    input  ninth_e        sel,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic          busy,
    output logic          txd
);
    localparam int FW = DW + 3;
    localparam int OW = $clog2(OVS);
    localparam int BW = $clog2(FW + 1);

    logic [FW-1:0] sh_q;
    logic [OW-1:0] tc_q;
    logic [BW-1:0] bc_q;
    logic [BW-1:0] last_bit;
    logic          busy_q, txd_q, nine_q;

    assign last_bit = nine_q ? BW'(FW - 1) : BW'(FW - 2);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '1;
            tc_q   <= '0;
            bc_q   <= '0;
            busy_q <= 1'b0;
            txd_q  <= 1'b1;
            nine_q <= 1'b0;
        end else if (!busy_q) begin
            if (wr) begin
                sh_q   <= {1'b1, (nine ? ninth_of(sel, wdata) : 1'b1), wdata, 1'b0};
                txd_q  <= 1'b0;
                busy_q <= 1'b1;
                tc_q   <= '0;
                bc_q   <= '0;
                nine_q <= nine;
            end
        end else if (tick) begin
            if (tc_q == OW'(OVS - 1)) begin
                tc_q <= '0;
                if (bc_q == last_bit) begin
                    busy_q <= 1'b0;
                    txd_q  <= 1'b1;
                end else begin
                    bc_q  <= bc_q + 1'b1;
                    sh_q  <= {1'b1, sh_q[FW-1:1]};
                    txd_q <= sh_q[1];
                end
            end else begin
                tc_q <= tc_q + 1'b1;
            end
        end
    end

    assign busy = busy_q;
    assign txd  = txd_q;

    AST_TX_START_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> !txd_q);   // R1
    AST_TX_STEADY_BIT: assert property (@(posedge clk) disable iff (rst)
        (busy_q && $past(busy_q) && !$past(tick)) |-> $stable(txd_q));   // R1
    AST_TX_END_ON_STOP: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> (txd_q && $past(txd_q)));   // R6

endmodule

// File: rtl/uart9_rx.sv
module uart9_rx
    import uart9_pkg::*;
#(
    parameter int DW  = uart9_pkg::DW,
    parameter int OVS = uart9_pkg::OVS
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     nine,
    input  logic     rxd,
    input  logic     rd,
    output logic     valid,
    output rx_word_t word
);
    localparam int OW   = $clog2(OVS);
    localparam int BW   = $clog2(DW + 1);
    localparam int SMP0 = OVS / 2 - 1;
    localparam int SMP1 = OVS / 2;
    localparam int SMP2 = OVS / 2 + 1;

    logic          s1_q, s2_q;
    line_e         st_q;
    logic [OW-1:0] tc_q;
    logic [BW-1:0] bc_q;
    logic [DW:0]   sh_q;
    logic [1:0]    v_q;
    logic          armed_q, nine_q, valid_q;
    rx_word_t      word_q;
    logic          maj, done;
    logic [BW-1:0] last_bit;

    assign maj      = vote3(v_q[0], v_q[1], s2_q);
    assign done     = tick && (st_q == LN_STOP) && (tc_q == OW'(SMP2));
    assign last_bit = nine_q ? BW'(DW) : BW'(DW - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q    <= 1'b1;
            s2_q    <= 1'b1;
            st_q    <= LN_IDLE;
            tc_q    <= '0;
            bc_q    <= '0;
            sh_q    <= '0;
            v_q     <= '0;
            armed_q <= 1'b0;
            nine_q  <= 1'b0;
            valid_q <= 1'b0;
            word_q  <= '0;
        end else begin
            s1_q <= rxd;
            s2_q <= s1_q;
            if (done) begin
                valid_q     <= 1'b1;
                word_q.data <= nine_q ? sh_q[DW-1:0] : sh_q[DW:1];
                word_q.bit9 <= nine_q ? sh_q[DW] : 1'b0;
                word_q.ferr <= !maj;
            end else if (rd) begin
                valid_q <= 1'b0;
            end
            if (tick) begin
                if (st_q == LN_IDLE) begin
                    if (!s2_q && armed_q) begin
                        st_q    <= LN_START;
                        tc_q    <= OW'(1);
                        armed_q <= 1'b0;
                        nine_q  <= nine;
                    end else if (s2_q) begin
                        armed_q <= 1'b1;
                    end
                end else begin
                    tc_q <= (tc_q == OW'(OVS - 1)) ? '0 : tc_q + 1'b1;
                    if (tc_q == OW'(SMP0)) v_q[0] <= s2_q;
                    if (tc_q == OW'(SMP1)) v_q[1] <= s2_q;
                    if (tc_q == OW'(SMP2)) begin
                        case (st_q)
                            LN_START: if (maj) st_q <= LN_IDLE;
                            LN_DATA:  sh_q <= {maj, sh_q[DW:1]};
                            LN_STOP:  st_q <= LN_IDLE;
                            default:  ;
                        endcase
                    end
                    if (tc_q == OW'(OVS - 1)) begin
                        case (st_q)
                            LN_START: begin
                                st_q <= LN_DATA;
                                bc_q <= '0;
                            end
                            LN_DATA: begin
                                if (bc_q == last_bit) st_q <= LN_STOP;
                                else                  bc_q <= bc_q + 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end
            end
        end
    end

    assign valid = valid_q;
    assign word  = word_q;

    AST_RX_DONE_VALID: assert property (@(posedge clk) disable iff (rst)
        done |=> valid_q);   // R8
    AST_RX_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd && !done) |=> !valid_q);   // R8
    AST_RX_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(word_q));   // R8
    AST_RX_START_FROM_LOW: assert property (@(posedge clk) disable iff (rst)
        (st_q == LN_START && $past(st_q) == LN_IDLE) |-> !$past(s2_q));   // R7

endmodule

// File: rtl/uart9.sv
module uart9
    import uart9_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode,
    input  logic       div_sel,
    input  logic [1:0] bit9_sel,
    input  logic       baud_tick,
    input  logic       tx_wr,
    input  logic [7:0] tx_data,
    output logic       tx_busy,
    output logic       txd,
    input  logic       rxd,
    input  logic       rx_rd,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       rx_bit9,
    output logic       rx_ferr
);
    fmt_e     fmt;
    ninth_e   n9;
    logic     tick;
    rx_word_t word;

    assign fmt = fmt_e'(mode);
    assign n9  = ninth_e'(bit9_sel);

    uart9_tick #(.OVS(OVS), .BIT_LO(32), .BIT_HI(64)) u_tick (
        .clk      (clk),
        .rst      (rst),
        .ext_sel  (fmt_ext(fmt)),
        .div_sel  (div_sel),
        .baud_tick(baud_tick),
        .tick     (tick)
    );

    uart9_tx #(.DW(DW), .OVS(OVS)) u_tx (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .nine (fmt_nine(fmt)),
        .sel  (n9),
        .wr   (tx_wr),
        .wdata(tx_data),
        .busy (tx_busy),
        .txd  (txd)
    );

    uart9_rx #(.DW(DW), .OVS(OVS)) u_rx (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .nine (fmt_nine(fmt)),
        .rxd  (rxd),
        .rd   (rx_rd),
        .valid(rx_valid),
        .word (word)
    );

    assign rx_data = word.data;
    assign rx_bit9 = word.bit9;
    assign rx_ferr = word.ferr;

endmodule

// File: tb/uart9_tb.sv
module uart9_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'b00;
    logic       div_sel = 1'b0;
    logic [1:0] bit9_sel = 2'b00;
    logic       baud_tick = 1'b0;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_busy, txd;
    logic       rxd = 1'b1;
    logic       rx_rd = 1'b0;
    logic       rx_valid, rx_data_unused;
    logic [7:0] rx_data;
    logic       rx_bit9, rx_ferr;

    int errs = 0;
    int checks = 0;
    int bp = 48;
    bit finished = 0;

    always #4 clk = ~clk;

    uart9 u_dut (
        .clk(clk), .rst(rst), .mode(mode), .div_sel(div_sel), .bit9_sel(bit9_sel),
        .baud_tick(baud_tick), .tx_wr(tx_wr), .tx_data(tx_data), .tx_busy(tx_busy),
        .txd(txd), .rxd(rxd), .rx_rd(rx_rd), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_bit9(rx_bit9), .rx_ferr(rx_ferr)
    );

    assign rx_data_unused = 1'b0;

    // external oversample pulse: one clock in three
    initial begin
        forever begin
            repeat (2) @(negedge clk);
            baud_tick = 1'b1;
            @(negedge clk);
            baud_tick = 1'b0;
        end
    end

    // fields: mode[12:11] div_sel[10] bit9_sel[9:8] data[7:0]
    localparam logic [12:0] VEC [8] = '{
        {2'b00, 1'b0, 2'b00, 8'hA5},
        {2'b01, 1'b0, 2'b00, 8'h3C},
        {2'b01, 1'b1, 2'b01, 8'h81},
        {2'b01, 1'b0, 2'b10, 8'h07},
        {2'b10, 1'b0, 2'b10, 8'h66},
        {2'b10, 1'b0, 2'b01, 8'h00},
        {2'b01, 1'b1, 2'b11, 8'hFF},
        {2'b11, 1'b0, 2'b00, 8'hF0}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic ninth_exp(input logic [1:0] s, input logic [7:0] d);
        if (s == 2'b00) return 1'b0;
        if (s == 2'b01) return 1'b1;
        return ^d;
    endfunction

    task automatic set_cfg(input logic [1:0] m, input logic dv, input logic [1:0] s);
        @(negedge clk);
        mode = m; div_sel = dv; bit9_sel = s;
        bp = (m == 2'b01) ? (dv ? 64 : 32) : 48;
        repeat (20) @(negedge clk);
    endtask

    // write a byte, decode txd at bit centres, compare with the expected frame
    task automatic send_tx(input logic [7:0] d, input logic [10:0] expv, input int nb,
                           input bit poke, input string req);
        logic [10:0] got = '0;
        @(negedge clk);
        tx_wr = 1'b1; tx_data = d;
        @(negedge clk);
        tx_wr = 1'b0; tx_data = 8'h00;
        chk(tx_busy == 1'b1, "R6", "busy after write", tx_busy, 1);
        repeat (bp / 2) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            got[i] = txd;
            if (i < nb - 1) begin
                if (poke && i == 1) begin
                    tx_wr = 1'b1; tx_data = ~d;
                    @(negedge clk);
                    tx_wr = 1'b0;
                    repeat (bp - 1) @(negedge clk);
                end else begin
                    repeat (bp) @(negedge clk);
                end
            end
        end
        chk(got == expv, req, "tx frame bits", got, expv);
        repeat (bp / 2 + 6) @(negedge clk);
        chk(tx_busy == 1'b0 && txd == 1'b1, "R6", "idle after stop", {tx_busy, txd}, 2'b01);
    endtask

    task automatic drive_rx(input logic [7:0] d, input logic b9, input bit nine, input logic stopv);
        @(negedge clk);
        rxd = 1'b0;
        repeat (bp) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i];
            repeat (bp) @(negedge clk);
        end
        if (nine) begin
            rxd = b9;
            repeat (bp) @(negedge clk);
        end
        rxd = stopv;
        repeat (bp) @(negedge clk);
        rxd = 1'b1;
    endtask

    task automatic rx_expect(input logic [7:0] d, input logic b9, input logic fe, input string req);
        chk(rx_valid == 1'b1, req, "rx_valid", rx_valid, 1);
        chk({rx_data, rx_bit9, rx_ferr} == {d, b9, fe}, req, "rx word",
            {rx_data, rx_bit9, rx_ferr}, {d, b9, fe});
    endtask

    task automatic rx_read;
        @(negedge clk);
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
        chk(rx_valid == 1'b0, "R8", "rx_valid after read", rx_valid, 0);
    endtask

    function automatic logic [10:0] frame_of(input logic [1:0] m, input logic [1:0] s,
                                             input logic [7:0] d);
        if (m == 2'b00) return {1'b0, 1'b1, d, 1'b0};
        return {1'b1, ninth_exp(s, d), d, 1'b0};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errs++; checks++;
            $display("FAIL watchdog: run did not complete actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk({txd, tx_busy, rx_valid, rx_data, rx_ferr} == {1'b1, 1'b0, 1'b0, 8'h00, 1'b0},
            "R10", "reset outputs", {txd, tx_busy, rx_valid, rx_data, rx_ferr}, 12'h800);

        // table: R1 R2 R3 R4 transmit, then receive the same character
        foreach (VEC[k]) begin
            logic [1:0] m;
            logic [1:0] s;
            logic [7:0] d;
            bit nine;
            m = VEC[k][12:11]; s = VEC[k][9:8]; d = VEC[k][7:0];
            nine = (m != 2'b00);
            set_cfg(m, VEC[k][10], s);
            send_tx(d, frame_of(m, s, d), nine ? 11 : 10, 1'b0,
                    (m == 2'b00) ? "R2" : ((m == 2'b01) ? "R4" : "R3"));
            drive_rx(d, ninth_exp(s, d), nine, 1'b1);
            rx_expect(d, nine ? ninth_exp(s, d) : 1'b0, 1'b0, nine ? "R3" : "R2");
            rx_read();
        end

        // R6: write while busy is ignored
        set_cfg(2'b01, 1'b0, 2'b10);
        send_tx(8'h4B, frame_of(2'b01, 2'b10, 8'h4B), 11, 1'b1, "R6");

        // R7: short low glitch is not a start bit
        @(negedge clk);
        rxd = 1'b0;
        repeat (6) @(negedge clk);
        rxd = 1'b1;
        repeat (100) @(negedge clk);
        chk(rx_valid == 1'b0, "R7", "glitch rejected", rx_valid, 0);
        drive_rx(8'h5A, 1'b0, 1'b1, 1'b1);
        rx_expect(8'h5A, 1'b0, 1'b0, "R7");
        rx_read();

        // R8: held word survives the next reception, then is replaced
        drive_rx(8'hC1, 1'b1, 1'b1, 1'b1);
        rx_expect(8'hC1, 1'b1, 1'b0, "R8");
        fork
            drive_rx(8'h2E, 1'b0, 1'b1, 1'b1);
            begin
                repeat (bp * 5) @(negedge clk);
                rx_expect(8'hC1, 1'b1, 1'b0, "R8");
            end
        join
        rx_expect(8'h2E, 1'b0, 1'b0, "R8");
        rx_read();

        // R9: stop bit low flags a framing error, then recovery
        drive_rx(8'h99, 1'b0, 1'b1, 1'b0);
        rx_expect(8'h99, 1'b0, 1'b1, "R9");
        rx_read();
        repeat (bp) @(negedge clk);
        drive_rx(8'h3D, 1'b1, 1'b1, 1'b1);
        rx_expect(8'h3D, 1'b1, 1'b0, "R9");
        rx_read();

        // R5: both directions at once
        set_cfg(2'b10, 1'b0, 2'b01);
        fork
            send_tx(8'hC3, frame_of(2'b10, 2'b01, 8'hC3), 11, 1'b0, "R5");
            drive_rx(8'h3C, 1'b1, 1'b1, 1'b1);
        join
        rx_expect(8'h3C, 1'b1, 1'b0, "R5");
        rx_read();

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule